// File: doc/BRIEF.md
# Output Margining Step Controller

This block decides when a regulator's output is pushed above or below its nominal level for margin testing, and spreads each change over a programmable slew time. Two control pins carry a command. One asks for a raised output, one asks for a lowered output. Driving neither leaves the level where it is. Driving both at once is discarded. A mode strap turns margining off altogether. In that mode the negative-direction pin is taken to be an analog reference input, and it is never read as a command.

The block drives a signed margin code. An analog stage outside the block turns this code into an offset, at 0.5% of nominal per LSB, so a code of 20 is 10%. The code walks one LSB per prescaled tick toward its target. A busy flag stays high while the code has not yet reached the target.

One prescaled timer serves two purposes. While power-good is low, it times the power-good delay. Once power-good is high, it paces the margin ramp. Commands therefore act only after start-up has finished and power-good has asserted.

Top module: `margin_step_ctrl`

## Requirements
- R1: Under reset, `margin_o` is 0, `busy_o` is 0 and `pgood_o` is 0.
- R2: `pgood_o` rises only after `pg_raw_i` has stayed high for PG_DELAY_TICKS timer ticks, where one tick is PRESCALE clocks; the defaults give 32 clocks. `pgood_o` falls on the first clock edge after `pg_raw_i` goes low.
- R3: While `pgood_o` is low or `strap_ext_ref_i` is high, the margin code is forced to 0 and the pins have no effect.
- R4: The pins {`pin_neg_i`,`pin_pos_i`} = 2'b01 set the target to +magnitude.
- R5: The pins {`pin_neg_i`,`pin_pos_i`} = 2'b10 set the target to -magnitude.
- R6: The pins = 2'b00 keep the present target, even when `mag_i` changes.
- R7: The pins = 2'b11 are ignored, and the present target is kept.
- R8: `mag_i` is clamped to MAG_MAX (default 20, i.e. 10%).
- R9: The code moves by exactly one LSB per tick (PRESCALE clocks) toward the target. `busy_o` is high while the code differs from the target.
- R10: A new command that arrives mid-slew turns the ramp toward the new target from the present code, without a jump.
- R11: The pins pass through a two-flop synchroniser. A pin pattern takes effect only after it has been stable for STABLE_CYC clocks. Shorter pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_ext_ref_i | input | 1 | Mode strap; high disables margining |
| pin_neg_i | input | 1 | Asynchronous command pin, lower output |
| pin_pos_i | input | 1 | Asynchronous command pin, raise output |
| pg_raw_i | input | 1 | Undelayed power-good (in window and soft-start done) |
| mag_i | input | MAG_W | Requested margin magnitude in LSBs |
| margin_o | output | CODE_W | Signed margin code |
| busy_o | output | 1 | Code has not reached target |
| pgood_o | output | 1 | Delayed power-good |

## Verification
A target register holding the wrong value shows up as a final code that disagrees with the last valid command. This becomes visible within one full slew, which is at most 2·MAG_MAX ticks. A fault in the prescaler or in timer ownership changes the clock count between the first and the last step of a ramp. It also moves the edge at which `pgood_o` rises, and both counts are measured to the clock. A faulty synchroniser filter lets a short pin pulse move `margin_o` away from zero. A missing clamp or a faulty redirect shows up as a code that passes the expected end point or jumps between adjacent samples.

// File: rtl/margin_pkg.sv
package margin_pkg;
  // bit order {pin_neg, pin_pos}
  typedef enum logic [1:0] {
    CMD_HOLD = 2'b00,
    CMD_UP   = 2'b01,
    CMD_DOWN = 2'b10,
    CMD_IGN  = 2'b11
  } cmd_e;
endpackage

// File: rtl/margin_sync.sv
module margin_sync #(
  parameter int W          = 2,
  parameter int STABLE_CYC = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] acc_o
);
  localparam int CW  = $clog2(STABLE_CYC + 1);
  localparam int LIM = STABLE_CYC - 1;

  logic [W-1:0] s1_q, s2_q, s3_q;
  logic [CW-1:0] cnt_q;

  for (genvar i = 0; i < W; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= raw_i[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_q  <= '0;
      cnt_q <= '0;
      acc_o <= '0;
    end else begin
      s3_q <= s2_q;
      if (s2_q != s3_q) cnt_q <= '0;
      else if (cnt_q != CW'(LIM)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(LIM)) acc_o <= s3_q;
    end
  end

  // R11: accepted value only ever takes a pattern that was already settled
  p_accept_settled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o != $past(acc_o)) |-> (acc_o == $past(s3_q)));
endmodule

// File: rtl/margin_timer.sv
module margin_timer #(
  parameter int PRESCALE       = 4,
  parameter int PG_DELAY_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_raw_i,
  output logic pgood_o,
  output logic slew_tick_o
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam int DW = $clog2(PG_DELAY_TICKS + 1);

  logic [PW-1:0] pre_q;
  logic [DW-1:0] dly_q;
  logic          tick;

  assign tick = (pre_q == PW'(PRESCALE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else if ((!pgood_o && !pg_raw_i) || tick) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  // owner: delay logic while pgood low, ramp while pgood high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgood_o <= 1'b0;
      dly_q   <= '0;
    end else if (pgood_o) begin
      dly_q <= '0;
      if (!pg_raw_i) pgood_o <= 1'b0;
    end else if (!pg_raw_i) begin
      dly_q <= '0;
    end else if (tick) begin
      if (dly_q == DW'(PG_DELAY_TICKS - 1)) begin
        pgood_o <= 1'b1;
        dly_q   <= '0;
      end else begin
        dly_q <= dly_q + 1'b1;
      end
    end
  end

  assign slew_tick_o = tick & pgood_o;

  p_pg_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgood_o && !pg_raw_i) |=> !pgood_o);
  p_pg_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> $past(pg_raw_i));
endmodule

// File: rtl/margin_target.sv
module margin_target
  import margin_pkg::*;
#(
  parameter int MAG_W   = 5,
  parameter int CODE_W  = 6,
  parameter int MAG_MAX = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  cmd_e                     cmd_i,
  input  logic [MAG_W-1:0]         mag_i,
  output logic signed [CODE_W-1:0] target_o
);
  logic signed [CODE_W-1:0] mag_s;

  always_comb begin
    int unsigned mv;
    mv = 32'(mag_i);
    if (mv > MAG_MAX) mv = MAG_MAX;
    mag_s = CODE_W'(mv);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) target_o <= '0;
    else if (!en_i) target_o <= '0;
    else begin
      unique case (cmd_i)
        CMD_UP:   target_o <= mag_s;
        CMD_DOWN: target_o <= -mag_s;
        default:  target_o <= target_o;
      endcase
    end
  end

  p_hold_r6_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (cmd_i == CMD_HOLD || cmd_i == CMD_IGN)) |=> $stable(target_o));
  p_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target_o <= CODE_W'(MAG_MAX)) && (target_o >= -CODE_W'(MAG_MAX)));
endmodule

// File: rtl/margin_ramp.sv
module margin_ramp #(
  parameter int CODE_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     tick_i,
  input  logic signed [CODE_W-1:0] target_i,
  output logic signed [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= '0;
    else if (!en_i) code_o <= '0;
    else if (tick_i && code_o < target_i) code_o <= code_o + 1'b1;
    else if (tick_i && code_o > target_i) code_o <= code_o - 1'b1;
  end

  p_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (code_o == '0));
  p_no_tick_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(code_o));
  p_unit_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((code_o - $past(code_o)) inside {-1, 0, 1}));
endmodule

// File: rtl/margin_step_ctrl.sv
module margin_step_ctrl
  import margin_pkg::*;
#(
  parameter int MAG_W          = 5,
  parameter int CODE_W         = 6,
  parameter int MAG_MAX        = 20,
  parameter int PRESCALE       = 4,
  parameter int PG_DELAY_TICKS = 8,
  parameter int STABLE_CYC     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_ext_ref_i,
  input  logic              pin_neg_i,
  input  logic              pin_pos_i,
  input  logic              pg_raw_i,
  input  logic [MAG_W-1:0]  mag_i,
  output logic [CODE_W-1:0] margin_o,
  output logic              busy_o,
  output logic              pgood_o
);
  logic [1:0]               pins_acc;
  logic                     slew_tick, en;
  logic signed [CODE_W-1:0] target, code;
  cmd_e                     cmd;

  margin_sync #(.W(2), .STABLE_CYC(STABLE_CYC)) i_sync (
    .clk_i, .rst_ni, .raw_i({pin_neg_i, pin_pos_i}), .acc_o(pins_acc));

  margin_timer #(.PRESCALE(PRESCALE), .PG_DELAY_TICKS(PG_DELAY_TICKS)) i_timer (
    .clk_i, .rst_ni, .pg_raw_i, .pgood_o, .slew_tick_o(slew_tick));

  assign en  = pgood_o & ~strap_ext_ref_i;
  assign cmd = cmd_e'(pins_acc);

  margin_target #(.MAG_W(MAG_W), .CODE_W(CODE_W), .MAG_MAX(MAG_MAX)) i_target (
    .clk_i, .rst_ni, .en_i(en), .cmd_i(cmd), .mag_i, .target_o(target));

  margin_ramp #(.CODE_W(CODE_W)) i_ramp (
    .clk_i, .rst_ni, .en_i(en), .tick_i(slew_tick), .target_i(target), .code_o(code));

  assign margin_o = code;
  assign busy_o   = (code != target);

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |=> (margin_o == '0 || !rst_ni));
endmodule

// File: tb/test_margin_step_ctrl.sv
module test_margin_step_ctrl;
  localparam int MAG_MAX = 20;
  localparam int PRESCALE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strap = 1'b0, pneg = 1'b0, ppos = 1'b0, pg_raw = 1'b0;
  logic [4:0] mag = '0;
  logic [5:0] margin;
  logic busy, pgood;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0, done = 1'b0;
  int max_jump = 0, peak = -100, prev_m = 0;

  always #2.5 clk = ~clk;

  margin_step_ctrl i_margin_step_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .strap_ext_ref_i(strap), .pin_neg_i(pneg),
    .pin_pos_i(ppos), .pg_raw_i(pg_raw), .mag_i(mag), .margin_o(margin),
    .busy_o(busy), .pgood_o(pgood));

  function automatic int sm(input logic [5:0] v);
    return int'($signed(v));
  endfunction

  function automatic int clampm(input int m);
    return (m > MAG_MAX) ? MAG_MAX : m;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pins(input logic [1:0] v);
    {pneg, ppos} = v;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      int d;
      d = sm(margin) - prev_m;
      if (d < 0) d = -d;
      if (d > max_jump) max_jump = d;
      if (sm(margin) > peak) peak = sm(margin);
    end
    prev_m = sm(margin);
  end

  initial begin
    int t0, t1, exp_t;
    logic [1:0] cur;
    clks(4);
    chk(margin == 0 && busy == 0 && pgood == 0, "R1 reset state", int'(margin) + busy + pgood, 0);
    rst_n = 1'b1;
    pg_raw = 1'b1;
    clks(25);
    chk(pgood == 1'b0, "R2 pgood early", pgood, 0);
    clks(20);
    chk(pgood == 1'b1, "R2 pgood after delay", pgood, 1);

    pins(2'b01); mag = 5'd10;
    clks(2);
    pins(2'b00);
    clks(100);
    chk(sm(margin) == 0, "R11 short pulse ignored", sm(margin), 0);

    pins(2'b01);
    clks(20);
    chk(busy == 1'b1, "R9 busy mid ramp", busy, 1);
    clks(100);
    chk(sm(margin) == 10 && !busy, "R4 positive margin", sm(margin), 10);

    pins(2'b10);
    while (sm(margin) == 10) @(negedge clk);
    t0 = 0;
    while (sm(margin) != -10) begin @(negedge clk); t0++; end
    chk(t0 == 19 * PRESCALE, "R9 slew clocks", t0, 19 * PRESCALE);
    chk(sm(margin) == -10, "R5 negative margin", sm(margin), -10);

    mag = 5'd20;
    clks(50);
    pins(2'b01);
    mon_on = 1'b1; peak = -100;
    while (sm(margin) != 0) @(negedge clk);
    pins(2'b10);
    clks(250);
    mon_on = 1'b0;
    chk(max_jump <= 1, "R10 no jump", max_jump, 1);
    chk(peak < 10, "R10 redirect peak", peak, 0);
    chk(sm(margin) == -20, "R10 redirect end", sm(margin), -20);

    pins(2'b11);
    clks(150);
    chk(sm(margin) == -20, "R7 both pins ignored", sm(margin), -20);
    pins(2'b00);
    clks(50);
    mag = 5'd3;
    clks(150);
    chk(sm(margin) == -20, "R6 hold keeps target", sm(margin), -20);

    mag = 5'd31;
    pins(2'b01);
    clks(250);
    chk(sm(margin) == 20, "R8 clamp", sm(margin), 20);

    strap = 1'b1;
    clks(3);
    chk(sm(margin) == 0, "R3 strap forces zero", sm(margin), 0);
    pins(2'b10);
    clks(100);
    chk(sm(margin) == 0, "R3 pins ignored under strap", sm(margin), 0);
    strap = 1'b0;
    clks(250);
    chk(sm(margin) == -20, "R5 after strap release", sm(margin), -20);

    pg_raw = 1'b0;
    clks(1);
    chk(pgood == 1'b0, "R2 pgood fall", pgood, 0);
    clks(2);
    chk(sm(margin) == 0, "R3 zero without pgood", sm(margin), 0);
    pg_raw = 1'b1;
    clks(300);
    chk(sm(margin) == -20 && pgood, "R2 restart ramp", sm(margin), -20);

    void'($urandom(32'd11));
    exp_t = -20; cur = 2'b10;
    for (int it = 0; it < 16; it++) begin
      int m;
      logic [1:0] c;
      m = int'($urandom_range(31, 0));
      c = 2'($urandom_range(3, 0));
      mag = 5'(m);
      clks(20);
      if (cur == 2'b01) exp_t = clampm(m);
      else if (cur == 2'b10) exp_t = -clampm(m);
      pins(c);
      cur = c;
      if (c == 2'b01) exp_t = clampm(m);
      else if (c == 2'b10) exp_t = -clampm(m);
      clks(250);
      t1 = sm(margin);
      chk(t1 == exp_t && !busy, "R4 R5 R6 R7 R8 random", t1, exp_t);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule